// File: doc/BRIEF.md
# Locked Access Sequence Tracker

This block watches the read and write address channels of an AXI3 port and follows the locked-access sequences that a manager issues. It is a pure observer. It drives nothing back onto the bus. It reports through a set of per-channel flags that a test environment or an on-chip error collector can sample. Two small counters track how many read and write bursts are in flight. A three-state machine follows each sequence through three phases: idle, held, and releasing after the unlocking request until that request completes.

When the first locked request is accepted, the tracker stores four things from it: its ID, the page of its address, its protection value and its cache value. Every later request in the same sequence is compared against these stored values. Hard protocol violations raise error flags. Good-practice deviations raise warning flags, and a parameter can switch the warning logic off entirely. All flags are combinational. Each one is valid in the same cycle as the request that causes it.

Top module: `lkt_lock_tracker`

## Requirements
- R1: While reset is asserted and after it, with no requests, `lock_state` reads 2'b00 (idle) and every error and warning flag is low.
- R2: The state encoding is 00 idle, 01 held, 10 releasing. The state moves as follows:
  - From idle to held on any address handshake whose lock field is 2'b10 (locked).
  - From held to releasing on any address handshake whose lock field is not 2'b10.
  - From releasing to idle at the clock edge that follows a cycle in which no read and no write burst is outstanding.
- R3: A read burst is outstanding from its address handshake until a read beat completes with the last-beat indicator set. A write burst is outstanding from its address handshake until the write-response handshake.
- R4: In the idle state, a valid locked request on one channel raises `err_start` for that channel if either of these holds:
  - some burst is outstanding, or
  - the other channel has a valid request that is not locked.
- R5: In the held state, a valid request whose ID differs from the stored ID raises `err_id` for its channel.
- R6: In the held state, a valid request that is not locked raises `err_unlock` for its channel if either of these holds:
  - some burst is outstanding, or
  - the other channel's address valid is high.
- R7: In the releasing state, a valid request raises `err_end` for its channel if either of these holds:
  - some burst is outstanding, or
  - the other channel is valid with a different lock field bit 1.
- R8: A valid request with lock field 2'b11 raises `err_reserved` for its channel in any state.
- R9: In the cycle in which reset is first released, a high address valid raises `err_valid_rst` for that channel. In later cycles the flag is low.
- R10: In the held state, each valid request raises warnings for its channel as follows:
  - `warn_region` when its address lies outside the stored 4 KB page;
  - `warn_attr` when its protection or cache value differs from the stored one;
  - `warn_count` when it is itself locked.
- R11: With `WARN_EN` = 0, all warning flags stay low whatever the stimulus.
- R12: The stored attributes come from the locked request that opened the sequence, whichever channel carried it. The write channel wins if both channels carry one in the same cycle.

In every two-bit flag vector, bit 0 is the write channel and bit 1 is the read channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write request ID |
| aw_addr | input | ADDR_W | Write address |
| aw_lock | input | 2 | Write lock field (00 normal, 01 exclusive, 10 locked, 11 reserved) |
| aw_prot | input | 3 | Write protection value |
| aw_cache | input | 4 | Write cache value |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read request ID |
| ar_addr | input | ADDR_W | Read address |
| ar_lock | input | 2 | Read lock field |
| ar_prot | input | 3 | Read protection value |
| ar_cache | input | 4 | Read cache value |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_last | input | 1 | Last read beat of a burst |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| lock_state | output | 2 | Current sequence state |
| err_valid_rst | output | 2 | Address valid high as reset released |
| err_reserved | output | 2 | Reserved lock value used |
| err_start | output | 2 | Locked start while not quiescent |
| err_id | output | 2 | ID differs inside a locked sequence |
| err_unlock | output | 2 | Unlocking request while not quiescent |
| err_end | output | 2 | New request before the unlocking one completed |
| warn_region | output | 2 | Request outside the stored 4 KB page |
| warn_attr | output | 2 | Protection or cache changed in sequence |
| warn_count | output | 2 | Further locked request inside a sequence |

## Verification
The counter assertions assume well-formed inputs. No last read beat and no write response arrives without a burst outstanding on that channel. The number of bursts in flight never exceeds `MAX_OUT`. The stimulus keeps to both assumptions. Every completion is driven only after the matching address handshake, and at most one burst per channel is ever in flight. The sweeps over lock values and IDs hold ready low, so the only bursts that enter the counters are the handshakes each scenario issues on purpose.

// File: rtl/lkt_pkg.sv
package lkt_pkg;

   typedef enum logic [1:0] {
      ST_OPEN    = 2'b00,
      ST_HELD    = 2'b01,
      ST_RELEASE = 2'b10
   } lk_state_e;

   localparam logic [1:0] LK_NORMAL = 2'b00;
   localparam logic [1:0] LK_EXCL   = 2'b01;
   localparam logic [1:0] LK_LOCKED = 2'b10;
   localparam logic [1:0] LK_RSVD   = 2'b11;

   // channel index inside every two-bit vector
   localparam int CH_WR = 0;
   localparam int CH_RD = 1;
   localparam int NCH   = 2;

endpackage

// File: rtl/lkt_burst_counter.sv
module lkt_burst_counter #(
   parameter int MAX_OUT = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic done_i,
   output logic idle_o
);
   localparam int CW = $clog2(MAX_OUT + 1);

   if (MAX_OUT < 1) begin : g_bad_max
      $error("lkt_burst_counter: MAX_OUT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i && !done_i) begin
         cnt_q <= cnt_q + CW'(1);
      end else if (!start_i && done_i) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign idle_o = (cnt_q == '0);

   // input assumption: completions only for bursts in flight (R3)
   p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |-> (cnt_q != '0));

   // input assumption: never more than MAX_OUT bursts in flight (R3)
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !done_i) |-> (cnt_q != CW'(MAX_OUT)));

endmodule

// File: rtl/lkt_lock_fsm.sv
module lkt_lock_fsm
   import lkt_pkg::*;
#(
   parameter int ID_W = 4,
   parameter int PG_W = 20
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NCH-1:0]            hs_i,
   input  logic [NCH-1:0][1:0]       lock_i,
   input  logic [NCH-1:0][ID_W-1:0]  id_i,
   input  logic [NCH-1:0][PG_W-1:0]  page_i,
   input  logic [NCH-1:0][2:0]       prot_i,
   input  logic [NCH-1:0][3:0]       cache_i,
   input  logic                      quiet_i,
   output lk_state_e                 state_o,
   output logic [ID_W-1:0]           cap_id_o,
   output logic [PG_W-1:0]           cap_page_o,
   output logic [2:0]                cap_prot_o,
   output logic [3:0]                cap_cache_o
);
   lk_state_e       state_q, state_d;
   logic [NCH-1:0]  locked_hs, plain_hs;
   logic            sel;
   logic [ID_W-1:0] cap_id_q;
   logic [PG_W-1:0] cap_page_q;
   logic [2:0]      cap_prot_q;
   logic [3:0]      cap_cache_q;

   for (genvar c = 0; c < NCH; c++) begin : g_hs
      assign locked_hs[c] = hs_i[c] && (lock_i[c] == LK_LOCKED);
      assign plain_hs[c]  = hs_i[c] && (lock_i[c] != LK_LOCKED);
   end

   // write channel takes priority when both open a sequence together
   assign sel = locked_hs[CH_WR] ? 1'b0 : 1'b1;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_OPEN:    if (|locked_hs) state_d = ST_HELD;
         ST_HELD:    if (|plain_hs)  state_d = ST_RELEASE;
         ST_RELEASE: if (quiet_i)    state_d = ST_OPEN;
         default:                    state_d = ST_OPEN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_OPEN;
         cap_id_q    <= '0;
         cap_page_q  <= '0;
         cap_prot_q  <= '0;
         cap_cache_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_OPEN && |locked_hs) begin
            cap_id_q    <= id_i[sel];
            cap_page_q  <= page_i[sel];
            cap_prot_q  <= prot_i[sel];
            cap_cache_q <= cache_i[sel];
         end
      end
   end

   assign state_o     = state_q;
   assign cap_id_o    = cap_id_q;
   assign cap_page_o  = cap_page_q;
   assign cap_prot_o  = cap_prot_q;
   assign cap_cache_o = cap_cache_q;

   p_enter_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OPEN && |locked_hs) |=> (state_q == ST_HELD));

   p_no_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RELEASE) |=> (state_q != ST_HELD));

   p_capture_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HELD && $past(state_q) == ST_HELD)
         |-> ($stable(cap_id_q) && $stable(cap_page_q)
              && $stable(cap_prot_q) && $stable(cap_cache_q)));

endmodule

// File: rtl/lkt_rule_check.sv
module lkt_rule_check
   import lkt_pkg::*;
#(
   parameter int ID_W    = 4,
   parameter int PG_W    = 20,
   parameter bit WARN_EN = 1'b1
) (
   input  lk_state_e                 state_i,
   input  logic [NCH-1:0]            valid_i,
   input  logic [NCH-1:0][1:0]       lock_i,
   input  logic [NCH-1:0][ID_W-1:0]  id_i,
   input  logic [NCH-1:0][PG_W-1:0]  page_i,
   input  logic [NCH-1:0][2:0]       prot_i,
   input  logic [NCH-1:0][3:0]       cache_i,
   input  logic [ID_W-1:0]           cap_id_i,
   input  logic [PG_W-1:0]           cap_page_i,
   input  logic [2:0]                cap_prot_i,
   input  logic [3:0]                cap_cache_i,
   input  logic                      quiet_i,
   input  logic                      rel_i,
   output logic [NCH-1:0]            e_rst_o,
   output logic [NCH-1:0]            e_rsvd_o,
   output logic [NCH-1:0]            e_start_o,
   output logic [NCH-1:0]            e_id_o,
   output logic [NCH-1:0]            e_unlock_o,
   output logic [NCH-1:0]            e_end_o,
   output logic [NCH-1:0]            w_region_o,
   output logic [NCH-1:0]            w_attr_o,
   output logic [NCH-1:0]            w_count_o
);
   logic in_open, in_held, in_rel;

   assign in_open = (state_i == ST_OPEN);
   assign in_held = (state_i == ST_HELD);
   assign in_rel  = (state_i == ST_RELEASE);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int O = NCH - 1 - c;

      logic is_lk, oth_lk, held_v;

      assign is_lk  = (lock_i[c] == LK_LOCKED);
      assign oth_lk = (lock_i[O] == LK_LOCKED);
      assign held_v = in_held && valid_i[c];

      assign e_rst_o[c]    = rel_i && valid_i[c];
      assign e_rsvd_o[c]   = valid_i[c] && (lock_i[c] == LK_RSVD);
      assign e_start_o[c]  = in_open && valid_i[c] && is_lk
                             && !(quiet_i && !(valid_i[O] && !oth_lk));
      assign e_id_o[c]     = held_v && (id_i[c] != cap_id_i);
      assign e_unlock_o[c] = held_v && !is_lk && !(quiet_i && !valid_i[O]);
      assign e_end_o[c]    = in_rel && valid_i[c]
                             && !(quiet_i && !(valid_i[O] && (lock_i[O][1] != lock_i[c][1])));

      if (WARN_EN) begin : g_warn
         assign w_region_o[c] = held_v && (page_i[c] != cap_page_i);
         assign w_attr_o[c]   = held_v && ((prot_i[c] != cap_prot_i)
                                           || (cache_i[c] != cap_cache_i));
         assign w_count_o[c]  = held_v && is_lk;
      end else begin : g_nowarn
         assign w_region_o[c] = 1'b0;
         assign w_attr_o[c]   = 1'b0;
         assign w_count_o[c]  = 1'b0;
      end
   end

endmodule

// File: rtl/lkt_lock_tracker.sv
module lkt_lock_tracker
   import lkt_pkg::*;
#(
   parameter int ID_W      = 4,
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   parameter int MAX_OUT   = 15,
   parameter bit WARN_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aw_valid,
   input  logic              aw_ready,
   input  logic [ID_W-1:0]   aw_id,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic [1:0]        aw_lock,
   input  logic [2:0]        aw_prot,
   input  logic [3:0]        aw_cache,
   input  logic              ar_valid,
   input  logic              ar_ready,
   input  logic [ID_W-1:0]   ar_id,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic [1:0]        ar_lock,
   input  logic [2:0]        ar_prot,
   input  logic [3:0]        ar_cache,
   input  logic              r_valid,
   input  logic              r_ready,
   input  logic              r_last,
   input  logic              b_valid,
   input  logic              b_ready,
   output logic [1:0]        lock_state,
   output logic [1:0]        err_valid_rst,
   output logic [1:0]        err_reserved,
   output logic [1:0]        err_start,
   output logic [1:0]        err_id,
   output logic [1:0]        err_unlock,
   output logic [1:0]        err_end,
   output logic [1:0]        warn_region,
   output logic [1:0]        warn_attr,
   output logic [1:0]        warn_count
);
   localparam int PG_W = ADDR_W - PAGE_BITS;

   if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("lkt_lock_tracker: PAGE_BITS must lie in 1..ADDR_W-1");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("lkt_lock_tracker: ID_W must be at least 1");
   end

   logic [NCH-1:0]            valid_v, hs_v, done_v, idle_v;
   logic [NCH-1:0][1:0]       lock_v;
   logic [NCH-1:0][ID_W-1:0]  id_v;
   logic [NCH-1:0][PG_W-1:0]  page_v;
   logic [NCH-1:0][2:0]       prot_v;
   logic [NCH-1:0][3:0]       cache_v;
   logic                      quiet;
   logic                      rel_q, rel_cycle;
   lk_state_e                 state;
   logic [ID_W-1:0]           cap_id;
   logic [PG_W-1:0]           cap_page;
   logic [2:0]                cap_prot;
   logic [3:0]                cap_cache;
   logic                      unused_lo;

   assign valid_v = {ar_valid, aw_valid};
   assign hs_v    = {ar_valid & ar_ready, aw_valid & aw_ready};
   assign done_v  = {r_valid & r_ready & r_last, b_valid & b_ready};
   assign lock_v  = {ar_lock, aw_lock};
   assign id_v    = {ar_id, aw_id};
   assign page_v  = {ar_addr[ADDR_W-1:PAGE_BITS], aw_addr[ADDR_W-1:PAGE_BITS]};
   assign prot_v  = {ar_prot, aw_prot};
   assign cache_v = {ar_cache, aw_cache};
   assign unused_lo = ^{aw_addr[PAGE_BITS-1:0], ar_addr[PAGE_BITS-1:0]};

   for (genvar c = 0; c < NCH; c++) begin : g_cnt
      lkt_burst_counter #(.MAX_OUT(MAX_OUT)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .start_i (hs_v[c]),
         .done_i  (done_v[c]),
         .idle_o  (idle_v[c])
      );
   end

   assign quiet = &idle_v;

   // first cycle after reset release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rel_q <= 1'b0;
      else        rel_q <= 1'b1;
   end
   assign rel_cycle = rst_n && !rel_q;

   lkt_lock_fsm #(.ID_W(ID_W), .PG_W(PG_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .hs_i        (hs_v),
      .lock_i      (lock_v),
      .id_i        (id_v),
      .page_i      (page_v),
      .prot_i      (prot_v),
      .cache_i     (cache_v),
      .quiet_i     (quiet),
      .state_o     (state),
      .cap_id_o    (cap_id),
      .cap_page_o  (cap_page),
      .cap_prot_o  (cap_prot),
      .cap_cache_o (cap_cache)
   );

   lkt_rule_check #(.ID_W(ID_W), .PG_W(PG_W), .WARN_EN(WARN_EN)) u_rules (
      .state_i     (state),
      .valid_i     (valid_v),
      .lock_i      (lock_v),
      .id_i        (id_v),
      .page_i      (page_v),
      .prot_i      (prot_v),
      .cache_i     (cache_v),
      .cap_id_i    (cap_id),
      .cap_page_i  (cap_page),
      .cap_prot_i  (cap_prot),
      .cap_cache_i (cap_cache),
      .quiet_i     (quiet),
      .rel_i       (rel_cycle),
      .e_rst_o     (err_valid_rst),
      .e_rsvd_o    (err_reserved),
      .e_start_o   (err_start),
      .e_id_o      (err_id),
      .e_unlock_o  (err_unlock),
      .e_end_o     (err_end),
      .w_region_o  (warn_region),
      .w_attr_o    (warn_attr),
      .w_count_o   (warn_count)
   );

   assign lock_state = state;

   p_rst_flag_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_valid_rst) |=> !(|err_valid_rst));

endmodule

// File: tb/lkt_lock_tracker_test.sv
`timescale 1ns/1ps
module lkt_lock_tracker_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        aw_valid, aw_ready, ar_valid, ar_ready;
   logic [3:0]  aw_id, ar_id;
   logic [31:0] aw_addr, ar_addr;
   logic [1:0]  aw_lock, ar_lock;
   logic [2:0]  aw_prot, ar_prot;
   logic [3:0]  aw_cache, ar_cache;
   logic        r_valid, r_ready, r_last, b_valid, b_ready;

   logic [1:0] lock_state, e_rst, e_rsvd, e_start, e_id, e_unlock, e_end, w_reg, w_attr, w_cnt;
   logic [1:0] n_state, n_rst, n_rsvd, n_start, n_id, n_unlock, n_end, n_reg, n_attr, n_cnt;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   lkt_lock_tracker #(.ID_W(4), .ADDR_W(32), .PAGE_BITS(12), .MAX_OUT(7), .WARN_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
      .aw_lock(aw_lock), .aw_prot(aw_prot), .aw_cache(aw_cache),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
      .ar_lock(ar_lock), .ar_prot(ar_prot), .ar_cache(ar_cache),
      .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
      .b_valid(b_valid), .b_ready(b_ready),
      .lock_state(lock_state), .err_valid_rst(e_rst), .err_reserved(e_rsvd),
      .err_start(e_start), .err_id(e_id), .err_unlock(e_unlock), .err_end(e_end),
      .warn_region(w_reg), .warn_attr(w_attr), .warn_count(w_cnt)
   );

   lkt_lock_tracker #(.ID_W(4), .ADDR_W(32), .PAGE_BITS(12), .MAX_OUT(7), .WARN_EN(1'b0)) uut_nowarn (
      .clk(clk), .rst_n(rst_n),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
      .aw_lock(aw_lock), .aw_prot(aw_prot), .aw_cache(aw_cache),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
      .ar_lock(ar_lock), .ar_prot(ar_prot), .ar_cache(ar_cache),
      .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
      .b_valid(b_valid), .b_ready(b_ready),
      .lock_state(n_state), .err_valid_rst(n_rst), .err_reserved(n_rsvd),
      .err_start(n_start), .err_id(n_id), .err_unlock(n_unlock), .err_end(n_end),
      .warn_region(n_reg), .warn_attr(n_attr), .warn_count(n_cnt)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   task automatic clr();
      aw_valid = 0; aw_ready = 0; aw_id = 0; aw_addr = 0; aw_lock = 0; aw_prot = 0; aw_cache = 0;
      ar_valid = 0; ar_ready = 0; ar_id = 0; ar_addr = 0; ar_lock = 0; ar_prot = 0; ar_cache = 0;
      r_valid = 0; r_ready = 0; r_last = 0; b_valid = 0; b_ready = 0;
   endtask

   task automatic put_aw(input logic rdy, input logic [3:0] id, input logic [31:0] a,
                         input logic [1:0] lk, input logic [2:0] pr, input logic [3:0] ca);
      aw_valid = 1; aw_ready = rdy; aw_id = id; aw_addr = a; aw_lock = lk; aw_prot = pr; aw_cache = ca;
   endtask

   task automatic put_ar(input logic rdy, input logic [3:0] id, input logic [31:0] a,
                         input logic [1:0] lk, input logic [2:0] pr, input logic [3:0] ca);
      ar_valid = 1; ar_ready = rdy; ar_id = id; ar_addr = a; ar_lock = lk; ar_prot = pr; ar_cache = ca;
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic settle();
      #1;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      report();
   end

   initial begin
      rst_n = 0;
      clr();
      repeat (3) nxt();
      settle();
      // R1: reset state
      chk("R1 state in reset", lock_state, 0);
      chk("R1 flags in reset", {e_rst, e_rsvd, e_start, e_id, e_unlock, e_end, w_reg, w_attr, w_cnt}, 0);

      // R9: valid high in release cycle
      nxt(); rst_n = 1; put_aw(0, 0, 0, 2'b00, 0, 0); settle();
      chk("R9 release cycle write valid", e_rst, 2'b01);
      nxt(); settle();
      chk("R9 later cycle", e_rst, 2'b00);
      nxt(); clr(); settle();
      chk("R1 idle after release", {lock_state, e_rsvd, e_start, e_id, e_unlock, e_end, w_reg, w_attr, w_cnt}, 0);

      // R8 / R4: sweep lock field pairs, idle and quiescent
      for (int wl = 0; wl < 4; wl++) begin
         for (int rl = 0; rl < 4; rl++) begin
            nxt(); clr();
            put_aw(0, 1, 32'h100, 2'(wl), 0, 0);
            put_ar(0, 1, 32'h200, 2'(rl), 0, 0);
            settle();
            chk("R8 reserved sweep", e_rsvd, {rl == 3, wl == 3});
            chk("R4 start sweep", e_start, {rl == 2 && wl != 2, wl == 2 && rl != 2});
         end
      end
      nxt(); clr(); settle();
      chk("R2 sweep leaves state idle", lock_state, 0);

      // R3: outstanding read blocks a locked start
      put_ar(1, 1, 32'h0, 2'b00, 0, 0);
      nxt(); clr(); put_aw(0, 1, 32'h0, 2'b10, 0, 0); settle();
      chk("R3 read outstanding", e_start, 2'b01);
      nxt(); r_valid = 1; r_ready = 1; r_last = 0; settle();
      chk("R3 non-last beat keeps outstanding", e_start, 2'b01);
      nxt(); r_last = 1; settle();
      chk("R3 last beat cycle still outstanding", e_start, 2'b01);
      nxt(); r_valid = 0; r_last = 0; settle();
      chk("R3 read completed", e_start, 2'b00);
      // write side
      nxt(); clr(); put_aw(1, 1, 32'h0, 2'b00, 0, 0);
      nxt(); clr(); put_ar(0, 1, 32'h0, 2'b10, 0, 0); settle();
      chk("R3 write outstanding", e_start, 2'b10);
      nxt(); b_valid = 1; b_ready = 1; settle();
      chk("R3 response cycle still outstanding", e_start, 2'b10);
      nxt(); b_valid = 0; settle();
      chk("R3 write completed", e_start, 2'b00);
      chk("R2 no handshake of locked kind", lock_state, 0);

      // write-opened sequence
      nxt(); clr(); put_aw(1, 5, 32'h1000_0100, 2'b10, 3'd2, 4'd3); settle();
      chk("R2 idle during opening cycle", lock_state, 0);
      nxt(); clr(); b_valid = 1; b_ready = 1; settle();
      chk("R2 held after locked handshake", lock_state, 1);
      for (int id = 0; id < 16; id++) begin
         nxt(); clr(); put_ar(0, 4'(id), 32'h1000_0200, 2'b10, 3'd2, 4'd3); settle();
         chk("R5 id sweep", e_id, {id != 5, 1'b0});
         chk("R10 count warning", w_cnt, 2'b10);
         chk("R11 warnings off", {n_reg, n_attr, n_cnt}, 0);
      end
      nxt(); clr(); put_ar(0, 5, 32'h1000_1000, 2'b00, 3'd2, 4'd3); settle();
      chk("R10 region warning", w_reg, 2'b10);
      chk("R10 attr unchanged", w_attr, 2'b00);
      chk("R6 quiet unlock legal", e_unlock, 2'b00);
      chk("R11 region off", n_reg, 2'b00);
      nxt(); ar_prot = 3'd3; ar_addr = 32'h1000_0FFC; settle();
      chk("R10 prot change", {w_reg, w_attr}, 4'b0010);
      nxt(); ar_prot = 3'd2; ar_cache = 4'd7; settle();
      chk("R10 cache change", w_attr, 2'b10);
      chk("R11 attr off", n_attr, 2'b00);
      // second locked read
      nxt(); clr(); put_ar(1, 5, 32'h1000_0300, 2'b10, 3'd2, 4'd3);
      nxt(); clr(); put_aw(0, 5, 32'h1000_0400, 2'b00, 3'd2, 4'd3); settle();
      chk("R2 locked handshake keeps held", lock_state, 1);
      chk("R6 unlock with read outstanding", e_unlock, 2'b01);
      nxt(); r_valid = 1; r_ready = 1; r_last = 1; settle();
      chk("R6 completion cycle", e_unlock, 2'b01);
      nxt(); r_valid = 0; r_last = 0; settle();
      chk("R6 quiet unlock", e_unlock, 2'b00);
      nxt(); put_ar(0, 5, 32'h1000_0400, 2'b00, 3'd2, 4'd3); settle();
      chk("R6 both channels valid", e_unlock, 2'b11);
      nxt(); clr(); put_aw(1, 5, 32'h1000_0400, 2'b00, 3'd2, 4'd3); settle();
      chk("R6 issued unlock", e_unlock, 2'b00);
      nxt(); clr(); put_ar(0, 5, 32'h1000_0400, 2'b00, 3'd2, 4'd3); settle();
      chk("R2 releasing", lock_state, 2);
      chk("R7 read while unlock outstanding", e_end, 2'b10);
      nxt(); clr(); put_aw(0, 5, 32'h1000_0400, 2'b00, 3'd2, 4'd3); settle();
      chk("R7 write while unlock outstanding", e_end, 2'b01);
      nxt(); clr(); b_valid = 1; b_ready = 1; settle();
      chk("R2 releasing until quiet", lock_state, 2);
      nxt(); clr();
      put_aw(0, 5, 32'h1000_0400, 2'b10, 3'd2, 4'd3);
      put_ar(0, 5, 32'h1000_0400, 2'b00, 3'd2, 4'd3);
      settle();
      chk("R2 releasing in quiet cycle", lock_state, 2);
      chk("R7 lock bit mismatch", e_end, 2'b11);
      nxt(); clr(); settle();
      chk("R2 back to idle", lock_state, 0);

      // read-opened sequence
      nxt(); put_ar(1, 9, 32'h2000_0040, 2'b10, 3'd1, 4'd2);
      nxt(); clr(); put_aw(0, 9, 32'h2000_0FFC, 2'b10, 3'd1, 4'd2); settle();
      chk("R12 held from read", lock_state, 1);
      chk("R12 stored from read channel", {e_id, w_reg, w_attr}, 0);
      chk("R10 count from write", w_cnt, 2'b01);
      nxt(); aw_id = 8; aw_addr = 32'h2000_1000; settle();
      chk("R12 id mismatch", e_id, 2'b01);
      chk("R12 page mismatch", w_reg, 2'b01);
      nxt(); aw_id = 9; aw_addr = 32'h2000_0000; aw_lock = 2'b11; settle();
      chk("R8 reserved while held", e_rsvd, 2'b01);
      nxt(); clr(); r_valid = 1; r_ready = 1; r_last = 1;
      nxt(); clr(); put_aw(1, 9, 32'h2000_0080, 2'b00, 3'd1, 4'd2);
      nxt(); clr(); b_valid = 1; b_ready = 1; settle();
      chk("R2 releasing after read-opened", lock_state, 2);
      nxt(); clr();
      put_aw(0, 9, 32'h2000_0080, 2'b00, 3'd1, 4'd2);
      put_ar(0, 9, 32'h2000_0080, 2'b00, 3'd1, 4'd2);
      settle();
      chk("R7 matching lock bits legal", e_end, 2'b00);
      nxt(); clr(); settle();
      chk("R2 idle at end", lock_state, 0);

      report();
   end

endmodule